// File: doc/BRIEF.md
# Conversion Result Bus Readout

This block puts a converter's result on a shared host data bus. A result is captured into a holding register when the converter signals end of conversion. The host reads it by pulling chip select and read low together. The bus has one output-enable bit per line, which stands in for tri-state drive.

The width of the read depends on a two-bit format code. In parallel format, the host gets the whole result in one read. In either byte format, an 8-bit host reads the result in two reads, choosing the half with the high-byte select input. When the high half is selected, the byte carries the top result bits, and its upper positions read as zero. In byte formats, the lines above the byte lane are released, because on the pin they carry the high-byte select and the serial functions. The two byte codes differ only in how a serial clock would run, so the parallel bus sees them as the same.

Top module: `result_readout`

## Requirements
- R1: After a synchronous active-low reset, the held result is zero, so a parallel read returns 12'h000.
- R2: Unless `cs_n` and `rd_n` are both low, every bit of `bus_oe` is 0 and `bus_data` is all zeros.
- R3: With `fmt_sel` = 2'b00 and a read active, `bus_oe` is 12'hFFF and `bus_data` equals the full held result, with bit 11 as the MSB.
- R4: Code `fmt_sel` = 2'b11 behaves exactly like 2'b00.
- R5: With `fmt_sel` = 2'b01 or 2'b10 and a read active, `bus_oe` is 12'h0FF and `bus_data[11:8]` is zero.
- R6: In a byte format with `hben` low, `bus_data[7:0]` carries result bits 7 down to 0.
- R7: In a byte format with `hben` high, `bus_data[7:4]` is zero and `bus_data[3:0]` carries result bits 11 down to 8.
- R8: The held result changes only on the clock edge where `conv_done` is high, and then it takes `conv_data`. A read taken while `conv_data` moves without `conv_done` returns the previous result.
- R9: In a parallel format, `hben` has no effect on the bus.
- R10: Byte codes 2'b01 and 2'b10 produce identical bus values for every input combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | End-of-conversion pulse; captures `conv_data` |
| conv_data | input | 12 | Converter result to be captured |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte select in byte formats |
| fmt_sel | input | 2 | Format: 00/11 parallel, 01 byte gated clock, 10 byte free clock |
| bus_data | output | 12 | Read data; zero where not enabled |
| bus_oe | output | 12 | Per-line drive enable |

## Verification
The case that is hardest to reach from the ports is a read made while the converter's output is already moving toward the next result. The bench holds chip select and read low and changes `conv_data` over several clock edges without `conv_done`, checking that the bus still shows the earlier value. It then pulses `conv_done` once and checks that the new value appears. Each format code is also swept with both halves of the byte and every strobe combination, using two result patterns that have different upper and lower nibbles.

// File: rtl/result_readout_pkg.sv
// Package: shared format codes for the result readout block.
// Assumes a two-bit format select; code 11 is folded onto parallel.
package result_readout_pkg;

    typedef enum logic [1:0] {
        FMT_PARALLEL  = 2'b00,
        FMT_BYTE_GATE = 2'b01,
        FMT_BYTE_FREE = 2'b10,
        FMT_PAR_ALIAS = 2'b11
    } fmt_code_e;

    // True when the code selects one of the byte/serial formats.
    function automatic logic fmt_is_byte(input logic [1:0] code);
        return (code == FMT_BYTE_GATE) || (code == FMT_BYTE_FREE);
    endfunction

endpackage

// File: rtl/result_hold.sv
// Module: result_hold
// Holds the last completed conversion result. It loads only on an
// end-of-conversion pulse and clears on synchronous active-low reset.
module result_hold #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] din,
    output logic [RES_W-1:0] q
);

    // Capture the new result at end of conversion only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/format_decode.sv
// Module: format_decode
// Turns the two-bit format code and the strobes into lane controls.
// Assumes strobes are active low and already synchronous to the host.
module format_decode
    import result_readout_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic [1:0] fmt_sel,
    output logic       rd_act,
    output logic       byte_mode
);

    // A read is active only while both strobes are low.
    always_comb begin
        rd_act    = !cs_n && !rd_n;
        byte_mode = fmt_is_byte(fmt_sel);
    end

endmodule

// File: rtl/lane_mux.sv
// Module: lane_mux
// Builds per-line data and drive enables. Lanes below BYTE_W carry either
// the full result bits or the selected byte. Lanes above it are released
// in byte mode. Undriven lanes show zero data.
module lane_mux #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic             rd_act,
    input  logic             byte_mode,
    input  logic             hben,
    input  logic [RES_W-1:0] held,
    output logic [RES_W-1:0] data,
    output logic [RES_W-1:0] oe
);

    localparam int HI_W  = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic [BYTE_W-1:0] byte_val;

    // Pick the high or low half, zero-padding the high half.
    always_comb begin
        if (hben) begin
            byte_val = {{PAD_W{1'b0}}, held[RES_W-1:BYTE_W]};
        end else begin
            byte_val = held[BYTE_W-1:0];
        end
    end

    for (genvar i = 0; i < RES_W; i++) begin : g_lane
        if (i < BYTE_W) begin : g_byte_lane
            // Byte lane: driven on any read, source depends on format.
            always_comb begin
                oe[i]   = rd_act;
                data[i] = rd_act && (byte_mode ? byte_val[i] : held[i]);
            end
        end else begin : g_upper_lane
            // Upper lane: driven only in parallel format.
            always_comb begin
                oe[i]   = rd_act && !byte_mode;
                data[i] = rd_act && !byte_mode && held[i];
            end
        end
    end

endmodule

// File: rtl/result_readout.sv
// Module: result_readout (top)
// Holds the converter result and presents it on a host bus either as a
// full word or as two bytes. Assumes RES_W > BYTE_W and RES_W <= 2*BYTE_W.
module result_readout #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic [1:0]       fmt_sel,
    output logic [RES_W-1:0] bus_data,
    output logic [RES_W-1:0] bus_oe
);

    logic [RES_W-1:0] held_q;
    logic             rd_act;
    logic             byte_mode;

    result_hold #(.RES_W(RES_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (conv_done),
        .din   (conv_data),
        .q     (held_q)
    );

    format_decode u_dec (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .fmt_sel   (fmt_sel),
        .rd_act    (rd_act),
        .byte_mode (byte_mode)
    );

    lane_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
        .rd_act    (rd_act),
        .byte_mode (byte_mode),
        .hben      (hben),
        .held      (held_q),
        .data      (bus_data),
        .oe        (bus_oe)
    );

endmodule

// File: rtl/result_readout_chk.sv
// Module: result_readout_chk
// Checker for result_readout. It relates the strobes, the format code and
// the held result to the bus. It is attached by bind below.
module result_readout_chk #(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_done,
    input logic [RES_W-1:0] conv_data,
    input logic             cs_n,
    input logic             rd_n,
    input logic             hben,
    input logic [1:0]       fmt_sel,
    input logic [RES_W-1:0] held,
    input logic [RES_W-1:0] bus_data,
    input logic [RES_W-1:0] bus_oe
);

    logic rd_on;
    logic is_byte;
    assign rd_on   = !cs_n && !rd_n;
    assign is_byte = (fmt_sel == 2'b01) || (fmt_sel == 2'b10);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_on |-> (bus_oe == '0 && bus_data == '0)); // R2
    AST_PAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && !is_byte) |-> (bus_oe == '1 && bus_data == held)); // R3
    AST_BYTE_UPPER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && is_byte) |-> (bus_oe[RES_W-1:BYTE_W] == '0 && bus_data[RES_W-1:BYTE_W] == '0)); // R5
    AST_HIGH_BYTE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_on && is_byte && hben) |-> (bus_data[BYTE_W-1:RES_W-BYTE_W] == '0)); // R7
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (held == $past(conv_data))); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(held)); // R8

endmodule

bind result_readout result_readout_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .hben      (hben),
    .fmt_sel   (fmt_sel),
    .held      (held_q),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe)
);

// File: tb/result_readout_tb.sv
module result_readout_tb;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        conv_done = 0;
    logic [11:0] conv_data = '0;
    logic        cs_n = 1;
    logic        rd_n = 1;
    logic        hben = 0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [11:0] bus_data;
    logic [11:0] bus_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    result_readout u_dut (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .cs_n(cs_n), .rd_n(rd_n), .hben(hben), .fmt_sel(fmt_sel),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected bus value from the requirements: {oe, data}.
    function automatic logic [23:0] model(input logic c, input logic r, input logic h,
                                          input logic [1:0] f, input logic [11:0] res);
        logic [11:0] oe, d;
        if (c || r) begin
            oe = 12'h000; d = 12'h000;                       // R2
        end else if (f == 2'b01 || f == 2'b10) begin
            oe = 12'h0FF;                                   // R5
            d  = h ? {8'h00, res[11:8]} : {4'h0, res[7:0]}; // R6 R7
        end else begin
            oe = 12'hFFF; d = res;                          // R3 R4
        end
        return {oe, d};
    endfunction

    task automatic load(input logic [11:0] v);
        @(negedge clk);
        conv_data = v; conv_done = 1;
        @(negedge clk);
        conv_done = 0;
    endtask

    task automatic set_bus(input logic c, input logic r, input logic h, input logic [1:0] f);
        cs_n = c; rd_n = r; hben = h; fmt_sel = f;
        #1;
    endtask

    task automatic t_reset();
        set_bus(0, 0, 0, 2'b00);
        check("R1 reset data", bus_data, 12'h000);
        check("R1 reset oe", bus_oe, 12'hFFF);
    endtask

    task automatic t_sweep(input logic [11:0] res);
        load(res);
        for (int k = 0; k < 32; k++) begin
            logic [23:0] e;
            set_bus(k[0], k[1], k[2], k[4:3]);
            e = model(k[0], k[1], k[2], k[4:3], res);
            check("R2/R3/R4/R5/R6/R7 sweep oe", bus_oe, e[23:12]);
            check("R2/R3/R4/R5/R6/R7 sweep data", bus_data, e[11:0]);
        end
    endtask

    task automatic t_hold();
        load(12'h5A3);
        set_bus(0, 0, 0, 2'b00);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            conv_data = 12'h0F0 + 12'(n);
            #1;
            check("R8 read during conversion", bus_data, 12'h5A3);
        end
        @(negedge clk);
        check("R8 still previous", bus_data, 12'h5A3);
        load(12'hC3E);
        set_bus(0, 0, 0, 2'b00);
        check("R8 new after done", bus_data, 12'hC3E);
    endtask

    task automatic t_hben_parallel();
        logic [11:0] a;
        load(12'h9B6);
        set_bus(0, 0, 0, 2'b00);
        a = bus_data;
        set_bus(0, 0, 1, 2'b00);
        check("R9 hben ignored 00", bus_data, a);
        set_bus(0, 0, 1, 2'b11);
        check("R9 hben ignored 11", bus_data, a);
        check("R4 alias full word", bus_data, 12'h9B6);
    endtask

    task automatic t_byte_codes();
        logic [11:0] a;
        load(12'hE71);
        for (int h = 0; h < 2; h++) begin
            set_bus(0, 0, h[0], 2'b01);
            a = bus_data;
            set_bus(0, 0, h[0], 2'b10);
            check("R10 byte codes equal", bus_data, a);
        end
        set_bus(0, 0, 1, 2'b10);
        check("R7 high byte", bus_data, 12'h00E);
        set_bus(0, 0, 0, 2'b01);
        check("R6 low byte", bus_data, 12'h071);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_sweep(12'hA5C);
        t_sweep(12'h3F1);
        t_hold();
        t_hben_parallel();
        t_byte_codes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule